// File: doc/BRIEF.md
# ADC Scan Sequencer with Differential Pairing

This block steps an eight-input converter front end through a scan. A start request snapshots a channel-enable mask and a differential flag. The block then visits the enabled channels in ascending order and issues one conversion request to an external converter for each of them. Each returned result is stored in a per-channel result register that carries a valid flag. When the scan finishes, the block raises a completion interrupt. If DMA is enabled, it instead raises a per-channel transfer request for every filled register.

In differential mode the inputs are grouped into four pairs: 0/1, 2/3, 4/5 and 6/7. The even member of each pair is the positive input. Every enabled member of a pair causes one conversion of that pair, and the result lands in the register of the member that triggered it. A pair with both members enabled is therefore converted twice.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `conv_start`, `conv_pair`, `res_valid` and `dma_req` are all zero.
- R2: A scan issues one `conv_start` pulse per enabled channel, in ascending channel index, and skips channels whose enable bit is 0. In single-ended mode, `conv_sel` equals the channel index and `conv_pair` is 0.
- R3: Each `conv_done` writes `conv_data` into the register of the channel being converted and sets its `res_valid` bit. A read (`rd_en`, `rd_idx`) returns the data and flag on `rd_data`/`rd_valid` one cycle later and clears that channel's valid bit.
- R4: In differential mode, `conv_pair` is 1 and `conv_sel` is the even channel of the pair. If only one member of a pair is enabled, exactly one conversion runs, and its result goes to the enabled member's register.
- R5: In differential mode with both members of a pair enabled, the pair is converted twice. The first result goes to the even register and the second to the odd register.
- R6: A start with an all-zero mask issues no conversion, leaves `busy` at 0, and signals completion in the cycle after the start.
- R7: `busy` rises in the cycle after a start and falls in the same cycle in which the last enabled channel's valid bit is set. A start request while `busy` is high has no effect.
- R8: On completion, `irq` pulses for exactly one cycle if `dma_en` is 0, and stays 0 if `dma_en` is 1.
- R9: While `dma_en` is 1, `dma_req[i]` is high exactly while register i is valid. Pulsing `dma_ack[i]` clears valid bit i, and with it `dma_req[i]`, in the next cycle.
- R10: Changes to `ch_en` and `diff_mode` while a scan is running do not alter that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 8 | Channel enable mask, bit i for channel i |
| diff_mode | input | 1 | 1 = differential pairs, 0 = single-ended |
| dma_en | input | 1 | 1 = DMA requests instead of interrupt |
| start | input | 1 | Scan start request, sampled while idle |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_sel | output | 3 | Input select for the converter |
| conv_pair | output | 1 | Converter should measure the pair of `conv_sel` |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| rd_en | input | 1 | Result read strobe |
| rd_idx | input | 3 | Result register to read |
| rd_data | output | 12 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Valid flag of the register read |
| res_valid | output | 8 | Valid flags of all result registers |
| dma_req | output | 8 | Per-channel transfer request |
| dma_ack | input | 8 | Per-channel transfer acknowledge |
| busy | output | 1 | Scan in progress |
| irq | output | 1 | Scan-complete pulse |

## Verification
The hardest case to reach is a differential scan in which both members of a pair are enabled. The two conversions share a select value, so they can be told apart only by which register each result ends up in. The converter model in the bench stamps every result with a running conversion number, so swapped or merged results show up on readback. Mid-scan changes to the mask, the mode and a second start request are driven while the first scan is still waiting on its converter. The test then confirms that the request sequence is exactly the one derived from the snapshot.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [0:0] {S_IDLE = 1'b0, S_WAIT = 1'b1} scan_state_t;

  // in pair mode the converter is pointed at the positive (even) input
  function automatic logic [7:0] pair_select(input logic [7:0] idx, input logic pair);
    pair_select = pair ? {idx[7:1], 1'b0} : idx;
  endfunction
endpackage

// File: rtl/adc_chan_picker.sv
module adc_chan_picker #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW:0]    base,
  output logic           found,
  output logic [CW-1:0]  idx
);
  // lowest enabled index at or above base
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(base))) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_en,
  input  logic           diff_mode,
  input  logic           dma_en,
  input  logic           start,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CW-1:0]  conv_sel,
  output logic           conv_pair,
  output logic           busy,
  output logic           irq,
  output logic           wr_en,
  output logic [CW-1:0]  wr_idx
);
  scan_state_t    state;
  logic [NCH-1:0] mask_q;
  logic           mode_q;
  logic [CW-1:0]  tgt;
  logic [NCH-1:0] pick_mask;
  logic [CW:0]    pick_base;
  logic           nxt_found;
  logic [CW-1:0]  nxt_idx;
  logic [7:0]     sel_wide;
  logic           sel_mode;

  assign pick_mask = (state == S_IDLE) ? ch_en : mask_q;
  assign pick_base = (state == S_IDLE) ? '0 : ({1'b0, tgt} + 1'b1);
  assign sel_mode  = (state == S_IDLE) ? diff_mode : mode_q;
  assign sel_wide  = pair_select(8'(nxt_idx), sel_mode);

  adc_chan_picker #(.NCH(NCH)) u_pick (
    .mask (pick_mask),
    .base (pick_base),
    .found(nxt_found),
    .idx  (nxt_idx)
  );

  assign wr_en  = (state == S_WAIT) && conv_done;
  assign wr_idx = tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mask_q     <= '0;
      mode_q     <= 1'b0;
      tgt        <= '0;
      conv_start <= 1'b0;
      conv_sel   <= '0;
      conv_pair  <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      irq        <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            mask_q <= ch_en;
            mode_q <= diff_mode;
            if (nxt_found) begin
              state      <= S_WAIT;
              busy       <= 1'b1;
              conv_start <= 1'b1;
              tgt        <= nxt_idx;
              conv_sel   <= sel_wide[CW-1:0];
              conv_pair  <= diff_mode;
            end else begin
              irq <= ~dma_en;
            end
          end
        end
        S_WAIT: begin
          if (conv_done) begin
            if (nxt_found) begin
              conv_start <= 1'b1;
              tgt        <= nxt_idx;
              conv_sel   <= sel_wide[CW-1:0];
            end else begin
              state     <= S_IDLE;
              busy      <= 1'b0;
              conv_pair <= 1'b0;
              irq       <= ~dma_en;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_start_in_scan: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);
  a_r2_sel_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(conv_done)) |-> $stable(conv_sel));
  a_r4_pair_even: assert property (@(posedge clk) disable iff (rst)
    conv_pair |-> !conv_sel[0]);
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r8_irq_not_dma: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(dma_en));
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_start);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [CW-1:0]  rd_idx,
  input  logic           dma_en,
  input  logic [NCH-1:0] dma_ack,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic [NCH-1:0] res_valid,
  output logic [NCH-1:0] dma_req
);
  logic [DW-1:0]  mem [NCH];
  logic [NCH-1:0] valid_n;

  // data array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_comb begin
    valid_n = res_valid & ~dma_ack;
    if (rd_en) valid_n[rd_idx] = 1'b0;
    if (wr_en) valid_n[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= '0;
      dma_req   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      res_valid <= valid_n;
      dma_req   <= valid_n & {NCH{dma_en}};
      rd_valid  <= rd_en && res_valid[rd_idx];
    end
  end

  a_r9_req_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (dma_req & ~res_valid) == '0);
  a_r3_write_sets: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> res_valid[$past(wr_idx)]);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (dma_ack != '0 && !wr_en) |=> ((res_valid & $past(dma_ack)) == '0));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_en,
  input  logic           diff_mode,
  input  logic           dma_en,
  input  logic           start,
  output logic           conv_start,
  output logic [CW-1:0]  conv_sel,
  output logic           conv_pair,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  input  logic           rd_en,
  input  logic [CW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic [NCH-1:0] res_valid,
  output logic [NCH-1:0] dma_req,
  input  logic [NCH-1:0] dma_ack,
  output logic           busy,
  output logic           irq
);
  logic          wr_en;
  logic [CW-1:0] wr_idx;

  adc_scan_ctrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .diff_mode (diff_mode),
    .dma_en    (dma_en),
    .start     (start),
    .conv_done (conv_done),
    .conv_start(conv_start),
    .conv_sel  (conv_sel),
    .conv_pair (conv_pair),
    .busy      (busy),
    .irq       (irq),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
  );

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (conv_data),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .dma_en   (dma_en),
    .dma_ack  (dma_ack),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .res_valid(res_valid),
    .dma_req  (dma_req)
  );

  a_r7_busy_ends_with_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(wr_en));
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ch_en = '0, dma_ack = '0;
  logic diff_mode = 1'b0, dma_en = 1'b0, start = 1'b0;
  logic conv_start, conv_pair, conv_done, rd_valid, busy, irq;
  logic [2:0] conv_sel;
  logic [DW-1:0] conv_data, rd_data;
  logic rd_en = 1'b0;
  logic [2:0] rd_idx = '0;
  logic [NCH-1:0] res_valid, dma_req;

  int checks = 0, errors = 0, cyc = 0;
  int conv_no = 0;
  int cnt = 0;
  logic [2:0] cap_sel;
  logic cap_pair;
  logic [3:0] exp_q [$];
  logic [DW-1:0] exp_val [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .ch_en(ch_en), .diff_mode(diff_mode), .dma_en(dma_en),
    .start(start), .conv_start(conv_start), .conv_sel(conv_sel), .conv_pair(conv_pair),
    .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .res_valid(res_valid), .dma_req(dma_req),
    .dma_ack(dma_ack), .busy(busy), .irq(irq));

  function automatic logic [DW-1:0] mk(input logic [2:0] s, input logic p, input int n);
    mk = {p, s, 8'(n)};
  endfunction

  // converter model: fixed latency, result stamped with a running number
  always @(posedge clk) begin
    if (rst) begin
      conv_done <= 1'b0; conv_data <= '0; cnt <= 0;
    end else begin
      conv_done <= 1'b0;
      if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          conv_done <= 1'b1;
          conv_data <= mk(cap_sel, cap_pair, conv_no);
          conv_no   <= conv_no + 1;
        end
      end
      if (conv_start) begin
        cap_sel <= conv_sel; cap_pair <= conv_pair; cnt <= 3;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop each conversion request against the scoreboard
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected conversion", {conv_pair, conv_sel}, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk({conv_pair, conv_sel} == e, "R2/R4 select order", {conv_pair, conv_sel}, e);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // driver: builds expectations, then runs one scan
  task automatic run_scan(input logic [NCH-1:0] m, input logic d, input logic dm,
                          input bit disturb, input string tag);
    int k = 0;
    int last = -1;
    int w = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) begin
      logic [2:0] s;
      s = d ? 3'(i & 6) : 3'(i);
      exp_q.push_back({d, s});
      exp_val[i] = mk(s, d, conv_no + k);
      k++; last = i;
    end
    ch_en = m; diff_mode = d; dma_en = dm; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (m == '0) begin
      chk(irq == !dm && busy == 0, {tag, " R6 empty completes"}, {busy, irq}, {1'b0, !dm});
      chk(exp_q.size() == 0, {tag, " R6 no request"}, exp_q.size(), 0);
      @(negedge clk);
      chk(irq == 0 && conv_start == 0, {tag, " R6 quiet after"}, {conv_start, irq}, 0);
      return;
    end
    chk(busy == 1, {tag, " R7 busy rises"}, busy, 1);
    if (disturb) begin
      @(negedge clk);
      ch_en = ~m; diff_mode = ~d; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy && w < 500) begin
      chk(irq == 0, {tag, " R8 no early irq"}, irq, 0);
      @(negedge clk); w++;
    end
    chk(res_valid[last] == 1, {tag, " R7 last written as busy falls"}, res_valid, 1 << last);
    chk(irq == !dm, {tag, " R8 completion irq"}, irq, !dm);
    chk(exp_q.size() == 0, {tag, " R2 all requests seen"}, exp_q.size(), 0);
    @(negedge clk);
    chk(irq == 0 && busy == 0 && conv_start == 0, {tag, " R7/R8 idle after"}, {busy, irq}, 0);
  endtask

  task automatic read_chk(input int i, input logic [DW-1:0] ev, input bit evld, input string tag);
    rd_en = 1'b1; rd_idx = 3'(i);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid == evld, {tag, " R3 read valid"}, rd_valid, evld);
    if (evld) chk(rd_data == ev, {tag, " R3 read data"}, rd_data, ev);
    chk(res_valid[i] == 0, {tag, " R3 read clears"}, res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && irq == 0 && conv_start == 0 && conv_pair == 0 && res_valid == 0 && dma_req == 0,
        "R1 reset state", {busy, irq, conv_start, conv_pair, res_valid, dma_req}, 0);

    // R2 single-ended, sparse mask
    run_scan(8'hA5, 1'b0, 1'b0, 0, "se");
    chk(res_valid == 8'hA5, "R3 valid flags", res_valid, 8'hA5);
    foreach (exp_val[i]) if (8'hA5 & (1 << i)) read_chk(i, exp_val[i], 1, "se");
    read_chk(1, '0, 0, "se-unset");

    // R4 one member per pair
    run_scan(8'h96, 1'b1, 1'b0, 0, "diff1");
    for (int i = 0; i < NCH; i++) if (8'h96 & (1 << i)) read_chk(i, exp_val[i], 1, "R4");

    // R5 both members of pairs, R10 disturbance mid-scan
    run_scan(8'h33, 1'b1, 1'b0, 1, "diff2");
    chk(res_valid == 8'h33, "R5 R10 valid flags", res_valid, 8'h33);
    for (int i = 0; i < NCH; i++) if (8'h33 & (1 << i)) read_chk(i, exp_val[i], 1, "R5");

    // R6 empty mask
    run_scan(8'h00, 1'b0, 1'b0, 0, "empty");

    // R9 DMA mode
    run_scan(8'h81, 1'b0, 1'b1, 0, "dma");
    chk(dma_req == 8'h81, "R9 dma requests", dma_req, 8'h81);
    dma_ack = 8'h80;
    @(negedge clk); dma_ack = '0;
    chk(dma_req == 8'h01 && res_valid == 8'h01, "R9 ack clears", {dma_req, res_valid}, 16'h0101);
    dma_en = 1'b0;
    @(negedge clk);
    chk(dma_req == 8'h00, "R9 requests need dma_en", dma_req, 0);
    read_chk(0, exp_val[0], 1, "R9");

    // R8 empty scan under DMA: no irq
    run_scan(8'h00, 1'b1, 1'b1, 0, "empty-dma");
    run_scan(8'h80, 1'b0, 1'b0, 0, "top");
    read_chk(7, exp_val[7], 1, "top");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule